// File: doc/BRIEF.md
# Generation-Tagged Event Queue Writer

This block turns interrupt notifications into 32-bit records and writes them, one after another, into a circular queue in memory. The queue holds a power-of-two number of bytes. The consumer keeps its own read index and decides whether a slot holds a fresh record by looking only at the top bit of that slot. No head or tail pointer passes between the two sides. The writer keeps a generation bit that it places in every record. The bit inverts each time the write index returns to slot 0. The consumer keeps a phase that inverts when its own index wraps. A slot is fresh when its top bit differs from the consumer's phase.

A notification carries either an interrupt number up to 24 bits wide or a flag that marks a software inter-processor interrupt. The flag is encoded as the reserved code 2^24. Accepted notifications become memory write requests that use a ready/valid handshake. Each record is stored with its most significant byte at the lowest address. An optional mode raises a notify pulse for every record written. A queue enable gates intake: while it is low, notifications are consumed, discarded and counted.

Top module: `evq_writer`

## Requirements
- R1: After reset, mem_wr_valid and notify are 0, drop_count is 0 and ntf_ready is 1. The first record goes to slot 0 with generation bit 1, so a zeroed queue shows no fresh slot to a consumer whose phase starts at 0.
- R2: A record holds the generation bit in bit 31 and the zero-extended code in bits 30:0. mem_wr_data carries the record byte-reversed: data bits 7:0 hold record bits 31:24, and data bits 31:24 hold record bits 7:0. The byte at data bits 8*i+7:8*i goes to byte address mem_wr_addr+i.
- R3: mem_wr_addr is the slot index times 4. The index advances by one for each accepted notification and wraps to 0 after slot QBYTES/4-1.
- R4: The generation bit is 1 for the first QBYTES/4 records and inverts each time the index wraps to 0. A consumer that starts at slot 0 with phase 0 and inverts its phase when it wraps sees every new record as fresh and the next unwritten slot as stale.
- R5: When ntf_ipi is 1, bits 30:0 of the record are 2^24 whatever ntf_num holds.
- R6: With cfg_notify_all at 1, notify is high for exactly one cycle, in the cycle after each write handshake. With cfg_notify_all at 0, notify stays 0.
- R7: With cfg_enable at 0, ntf_ready is 1, a notification issues no write, drop_count increases by one, and the slot index does not change.
- R8: While mem_wr_valid is 1 and mem_wr_ready is 0, mem_wr_addr and mem_wr_data hold their values and ntf_ready is 0 while the queue is enabled.
- R9: drop_count saturates at its all-ones value and never decreases until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Queue enable; when low, notifications are dropped |
| cfg_notify_all | input | 1 | Raise notify for every record written |
| ntf_valid | input | 1 | Notification request |
| ntf_ready | output | 1 | Notification accepted this cycle |
| ntf_ipi | input | 1 | Request is a software inter-processor interrupt |
| ntf_num | input | NUM_W | Logical interrupt number |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | log2(QBYTES) | Byte offset of the slot in the queue |
| mem_wr_data | output | 32 | Record in memory byte order |
| notify | output | 1 | One-cycle pulse after a record is written |
| drop_count | output | DROP_W | Saturating count of dropped notifications |

## Verification
A notification accepted at one clock edge appears on mem_wr_valid, mem_wr_addr and mem_wr_data after that same edge. The write lands in the bench memory at the next edge when ready is high, and notify follows one cycle after that handshake. The bench drives on the falling edge and samples each result at the falling edge where it is due: write fields one half cycle after acceptance, and notify plus memory contents one full cycle later. drop_count is read at the falling edge after each dropped request. Stall behaviour is sampled at several falling edges while mem_wr_ready is held low.

// File: rtl/evq_writer.sv
module evq_writer #(
  parameter int QBYTES = 64,
  parameter int NUM_W  = 24,
  parameter int DROP_W = 8,
  localparam int DEPTH = QBYTES / 4,
  localparam int IW    = $clog2(DEPTH),
  localparam int AW    = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_notify_all,
  input  logic              ntf_valid,
  output logic              ntf_ready,
  input  logic              ntf_ipi,
  input  logic [NUM_W-1:0]  ntf_num,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              notify,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [30:0] IPI_CODE = 31'(1) << NUM_W;

  logic [IW-1:0] idx;
  logic          gen;
  logic [31:0]   rec;
  logic [AW-1:0] addr_q;
  logic          wv;
  logic          ntf_q;
  logic [DROP_W-1:0] drops;

  wire         hs   = wv && mem_wr_ready;
  wire         take = ntf_valid && cfg_enable && (!wv || mem_wr_ready);
  wire         drop = ntf_valid && !cfg_enable;
  wire [30:0]  code = ntf_ipi ? IPI_CODE : 31'(ntf_num);

  assign ntf_ready    = !cfg_enable || !wv || mem_wr_ready;
  assign mem_wr_valid = wv;
  assign mem_wr_addr  = addr_q;
  assign mem_wr_data  = {rec[7:0], rec[15:8], rec[23:16], rec[31:24]};
  assign notify       = ntf_q;
  assign drop_count   = drops;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      gen    <= 1'b1;
      rec    <= '0;
      addr_q <= '0;
      wv     <= 1'b0;
      ntf_q  <= 1'b0;
      drops  <= '0;
    end else begin
      if (take) begin
        rec    <= {gen, code};
        addr_q <= {idx, 2'b00};
        idx    <= idx + 1'b1;
        if (&idx) gen <= ~gen;
        wv     <= 1'b1;
      end else if (hs) begin
        wv <= 1'b0;
      end
      ntf_q <= hs && cfg_notify_all;
      if (drop && !(&drops)) drops <= drops + 1'b1;
    end
  end
endmodule

module evq_writer_chk #(
  parameter int QBYTES = 64,
  parameter int DROP_W = 8,
  localparam int AW    = $clog2(QBYTES / 4) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              ntf_valid,
  input logic              ntf_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [AW-1:0]     mem_wr_addr,
  input logic [31:0]       mem_wr_data,
  input logic              notify,
  input logic [DROP_W-1:0] drop_count
);
  logic seen, prev_gen, prev_last;
  wire  hs = mem_wr_valid && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; prev_gen <= 1'b1; prev_last <= 1'b0;
    end else if (hs) begin
      seen      <= 1'b1;
      prev_gen  <= mem_wr_data[7];
      prev_last <= (mem_wr_addr == AW'(QBYTES - 4));
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready && cfg_enable |-> !ntf_ready);
  // R6
  notify_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past(hs));
  // R7
  disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable && ntf_valid && !mem_wr_valid |=> !mem_wr_valid);
  // R4
  gen_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && seen |-> mem_wr_data[7] == (prev_last ? !prev_gen : prev_gen));
  // R9
  drop_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_count >= $past(drop_count));
endmodule

bind evq_writer evq_writer_chk #(.QBYTES(QBYTES), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .ntf_valid(ntf_valid),
  .ntf_ready(ntf_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .notify(notify),
  .drop_count(drop_count)
);

// File: tb/tb_evq_writer.sv
module tb_evq_writer;
  localparam int CLK_PERIOD = 10;
  localparam int QBYTES = 64;
  localparam int NUM_W  = 24;
  localparam int DROP_W = 8;
  localparam int DEPTH  = QBYTES / 4;
  localparam int AW     = $clog2(DEPTH) + 2;
  localparam int NVEC   = 20;
  // bit 24 = IPI flag, bits 23:0 = number
  localparam logic [24:0] VEC [NVEC] = '{
    25'h0000001, 25'h0000002, 25'h0FFFFFF, 25'h1000000, 25'h0123456,
    25'h0ABCDEF, 25'h1FFFFFF, 25'h0000000, 25'h0800000, 25'h0000100,
    25'h0055AA5, 25'h0000010, 25'h1000123, 25'h07F0F0F, 25'h0000ACE,
    25'h0FEDCBA, 25'h0000003, 25'h1ABCDEF, 25'h0424242, 25'h0000007};

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_notify_all = 0;
  logic ntf_valid = 0, ntf_ipi = 0, mem_wr_ready = 1;
  logic [NUM_W-1:0] ntf_num = '0;
  logic ntf_ready, mem_wr_valid, notify;
  logic [AW-1:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic [DROP_W-1:0] drop_count;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mem [QBYTES];
  int tidx = 0; logic tgen = 1'b1;
  int cidx = 0; logic cphase = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_writer #(.QBYTES(QBYTES), .NUM_W(NUM_W), .DROP_W(DROP_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_notify_all(cfg_notify_all),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_ipi(ntf_ipi), .ntf_num(ntf_num),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .notify(notify), .drop_count(drop_count));

  always @(posedge clk)
    if (mem_wr_valid && mem_wr_ready)
      for (int i = 0; i < 4; i++) mem[int'(mem_wr_addr) + i] <= mem_wr_data[8*i +: 8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap(input logic [31:0] r);
    return {r[7:0], r[15:8], r[23:16], r[31:24]};
  endfunction

  function automatic logic [31:0] rd_slot(input int s);
    return {mem[4*s], mem[4*s+1], mem[4*s+2], mem[4*s+3]};
  endfunction

  task automatic send(input logic ipi, input logic [NUM_W-1:0] num, input string tag);
    logic [31:0] erec;
    logic [31:0] got;
    erec = {tgen, ipi ? 31'(1) << NUM_W : 31'(num)};
    @(negedge clk);
    ntf_valid = 1; ntf_ipi = ipi; ntf_num = num;
    chk(ntf_ready === 1'b1, "R1 ready", 32'(ntf_ready), 1);
    @(negedge clk);
    ntf_valid = 0;
    chk(mem_wr_valid === 1'b1, "R3 valid", 32'(mem_wr_valid), 1);
    chk(mem_wr_addr === AW'(tidx * 4), "R3 addr", 32'(mem_wr_addr), 32'(tidx * 4));
    chk(mem_wr_data === swap(erec), {tag, " R2 data"}, mem_wr_data, swap(erec));
    if (tidx == DEPTH - 1) tgen = ~tgen;
    tidx = (tidx + 1) % DEPTH;
    @(negedge clk);
    chk(notify === cfg_notify_all, "R6 notify", 32'(notify), 32'(cfg_notify_all));
    got = rd_slot(cidx);
    chk(got[31] !== cphase && got === erec, "R4 consumer fresh", got, erec);
    if (cidx == DEPTH - 1) cphase = ~cphase;
    cidx = (cidx + 1) % DEPTH;
    got = rd_slot(cidx);
    chk(got[31] === cphase, "R4 consumer stale next", 32'(got[31]), 32'(cphase));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0, d0;
    for (int i = 0; i < QBYTES; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_wr_valid === 1'b0, "R1 wr_valid", 32'(mem_wr_valid), 0);
    chk(notify === 1'b0, "R1 notify", 32'(notify), 0);
    chk(drop_count === '0, "R1 drops", 32'(drop_count), 0);
    chk(ntf_ready === 1'b1, "R1 ready", 32'(ntf_ready), 1);

    cfg_enable = 1; cfg_notify_all = 1;
    for (int v = 0; v < NVEC; v++)
      send(VEC[v][24], VEC[v][23:0], VEC[v][24] ? "R5 ipi" : "R2 num");

    // R5: ipi ignores number
    send(1'b1, 24'h5A5A5A, "R5 ipi");

    // R6: notify off
    cfg_notify_all = 0;
    send(1'b0, 24'h000042, "R6 off");
    cfg_notify_all = 1;

    // R7: disabled drops
    cfg_enable = 0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      ntf_valid = 1; ntf_num = 24'(k);
      chk(ntf_ready === 1'b1, "R7 ready", 32'(ntf_ready), 1);
      @(negedge clk);
      ntf_valid = 0;
      chk(mem_wr_valid === 1'b0, "R7 no write", 32'(mem_wr_valid), 0);
      chk(drop_count === DROP_W'(k), "R7 count", 32'(drop_count), 32'(k));
    end
    cfg_enable = 1;
    send(1'b0, 24'h000777, "R7 index kept");

    // R8: backpressure
    mem_wr_ready = 0;
    @(negedge clk);
    ntf_valid = 1; ntf_ipi = 0; ntf_num = 24'h00BEEF;
    @(negedge clk);
    ntf_num = 24'h00CAFE;
    a0 = 32'(mem_wr_addr); d0 = mem_wr_data;
    chk(a0 == 32'(tidx * 4), "R8 addr", a0, 32'(tidx * 4));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_wr_valid === 1'b1, "R8 held valid", 32'(mem_wr_valid), 1);
      chk(32'(mem_wr_addr) === a0 && mem_wr_data === d0, "R8 stable", mem_wr_data, d0);
      chk(ntf_ready === 1'b0, "R8 ready low", 32'(ntf_ready), 0);
    end
    ntf_valid = 0;
    mem_wr_ready = 1;
    @(negedge clk);
    chk(mem_wr_valid === 1'b0, "R8 drained", 32'(mem_wr_valid), 0);
    chk(rd_slot(tidx) === {tgen, 31'h00BEEF}, "R8 mem", rd_slot(tidx), {tgen, 31'h00BEEF});
    if (tidx == DEPTH - 1) tgen = ~tgen;
    tidx = (tidx + 1) % DEPTH;
    cidx = tidx;

    // R9: saturation
    cfg_enable = 0;
    @(negedge clk);
    ntf_valid = 1;
    repeat (260) @(negedge clk);
    ntf_valid = 0;
    chk(drop_count === '1, "R9 saturate", 32'(drop_count), 32'(2**DROP_W - 1));
    @(negedge clk);
    chk(drop_count === '1, "R9 hold", 32'(drop_count), 32'(2**DROP_W - 1));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule